// File: doc/BRIEF.md
# I2S Stereo Receive Channel

This block captures two-channel audio arriving on a standard I2S serial line. It turns each left and right sample into a 32-bit word and queues the words in a small FIFO. A host read port or a DMA request drains the FIFO. A mode input selects whether the block generates the bit clock and word select itself or follows clocks supplied from outside. In both modes the serial lines are sampled in the system clock domain through one shared synchronizer.

Capture is gated by an enable input and only starts at the first word-select change after the enable goes high, so a partially received slot is never stored. Samples are kept in left/right pairs, and one FIFO entry holds a whole pair. The reported fill level therefore moves only when a right sample completes a pair that began with a left sample. The sample size is 8 or 16 bits per channel. A polarity input chooses which word-select level means left.

Top module: `i2s_rx`

## Requirements
- R1: After reset the fill count is 0, the DMA request and the overflow flag are low, and the read data is zero.
- R2: In 16-bit mode a pair is stored as one word with the left sample in bits [15:0] and the right sample in bits [31:16]. Each sample is received MSB first, starting with the bit sampled on the second rising bit-clock edge after a word-select change.
- R3: In 8-bit mode the left sample is stored in bits [7:0], the right sample in bits [15:8], and bits [31:16] are zero.
- R4: With polarity 0 a low word select marks the left channel. With polarity 1 a high word select marks the left channel.
- R5: Nothing is stored while the enable is low. After the enable rises, capture starts only at the next word-select change, and a slot already in progress is discarded.
- R6: The fill count increases only when a right sample completes. A left sample on its own, or a right sample with no left sample before it, adds nothing.
- R7: The FIFO holds DEPTH pairs (16 by default). A pair that completes while the FIFO is full is dropped and sets a sticky overflow flag, and the count stays at DEPTH.
- R8: A flush empties the FIFO, sets the count to 0 and clears the overflow flag.
- R9: The DMA request is high exactly when the count is non-zero. A read of an empty FIFO returns zero and leaves the count at zero.
- R10: In master mode the bit clock period is 2*DIV system clocks, and word select toggles on a falling bit-clock edge once per slot of 8 or 16 bit clocks. Data received with these generated clocks is stored as in R2.
- R11: Pairs are read out in arrival order, and each read pulse removes exactly one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Capture enable |
| flush | input | 1 | Empties the FIFO and clears the overflow flag |
| is_master | input | 1 | 1: generate bit clock and word select; 0: follow external clocks |
| bits16 | input | 1 | 1: 16 bits per channel; 0: 8 bits per channel |
| lr_pol | input | 1 | Word-select level that marks the left channel |
| sck_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated word select (master mode) |
| rd_en | input | 1 | Read pulse; removes the head entry |
| rd_data | output | 32 | Head entry, zero when the FIFO is empty |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored pairs |
| dma_req | output | 1 | High while the FIFO holds at least one pair |
| overflow | output | 1 | Sticky flag for a pair dropped while full |

## Verification
The samples sent include all-ones against all-zeros, patterns with only the end bits set (0x8001/0x7FFE), and irregular values. These expose bit-order reversal, an off-by-one in the capture window, and left/right swaps in the packing. Sending the same traffic with each polarity shows whether the word-select level is mapped to the correct channel. Sending it in 8-bit mode shows whether the upper bits are cleared. The bench also raises the enable in the middle of a left slot, stops a stream half-way through a pair, and sends one pair more than the FIFO holds. These cases separate correct pair accounting and overflow handling from designs that count single samples or wrap around. A final run with generated clocks tests the master timing together with capture.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    localparam int WORD_W = 32;
    localparam int SMP_W  = 16;
    localparam int IDX_W  = 5;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SMP_W-1:0]  smp_t;
endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic bits16,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic sck_o,
    output logic ws_o,
    output logic rise,
    output logic ws_s,
    output logic sd_s
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             sck;
        logic             ws;
        logic [3:0]       falls;
        logic [2:0]       sync1;
        logic [2:0]       sync2;
        logic             sck_last;
    } gen_st_t;

    gen_st_t q, n;
    logic [3:0] slot_last;

    always_comb begin
        n = q;
        slot_last = bits16 ? 4'd15 : 4'd7;
        if (!is_master) begin
            n.div   = '0;
            n.sck   = 1'b0;
            n.ws    = 1'b0;
            n.falls = '0;
        end else if (q.div == DIV_W'(DIV - 1)) begin
            n.div = '0;
            n.sck = ~q.sck;
            if (q.sck) begin
                if (q.falls >= slot_last) begin
                    n.falls = '0;
                    n.ws    = ~q.ws;
                end else begin
                    n.falls = q.falls + 4'd1;
                end
            end
        end else begin
            n.div = q.div + DIV_W'(1);
        end
        n.sync1    = {sd_i, is_master ? q.ws : ws_i, is_master ? q.sck : sck_i};
        n.sync2    = q.sync1;
        n.sck_last = q.sync2[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sck_o = q.sck;
    assign ws_o  = q.ws;
    assign rise  = q.sync2[0] & ~q.sck_last;
    assign ws_s  = q.sync2[1];
    assign sd_s  = q.sync2[2];

    // R10: generated word select only moves together with a falling bit clock
    assert_ws_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !$stable(q.ws)) |-> $fell(q.sck));
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  flush,
    input  logic  bits16,
    input  logic  lr_pol,
    input  logic  rise,
    input  logic  ws_s,
    input  logic  sd_s,
    output logic  push,
    output word_t pdata
);
    typedef struct packed {
        logic             ws_last;
        logic             ch;
        logic             valid;
        logic [IDX_W-1:0] cnt;
        smp_t             shreg;
        smp_t             left;
        logic             held;
    } des_st_t;

    des_st_t q, n;
    logic [IDX_W-1:0] nbits;
    logic [IDX_W-1:0] idx;
    smp_t             sample;

    always_comb begin
        n      = q;
        push   = 1'b0;
        pdata  = '0;
        nbits  = bits16 ? IDX_W'(16) : IDX_W'(8);
        idx    = (q.cnt <= nbits) ? q.cnt + IDX_W'(1) : q.cnt;
        sample = {q.shreg[SMP_W-2:0], sd_s};
        if (rise) begin
            if (q.valid && idx <= nbits) n.shreg = sample;
            if (q.valid && idx == nbits) begin
                if (!q.ch) begin
                    n.left = sample;
                    n.held = 1'b1;
                end else if (q.held) begin
                    push   = 1'b1;
                    n.held = 1'b0;
                    pdata  = bits16 ? {sample, q.left}
                                    : {16'h0000, sample[7:0], q.left[7:0]};
                end
            end
            if (ws_s != q.ws_last) begin
                n.cnt   = '0;
                n.ch    = ws_s ^ lr_pol;
                n.valid = en;
            end else begin
                n.cnt = idx;
            end
            n.ws_last = ws_s;
        end
        if (!en) begin
            n.valid = 1'b0;
            n.held  = 1'b0;
        end
        if (flush) n.held = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R6: a pair leaves only when a left sample is waiting
    assert_push_after_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> q.held);
    // R5: a low enable silences the next cycle
    assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !push);
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo
    import i2s_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  word_t                        pdata,
    input  logic                         pop_req,
    output word_t                        rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct {
        word_t            mem [DEPTH];
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t q, n;
    logic full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        n       = q;
        full    = (q.cnt == CNT_W'(DEPTH));
        do_pop  = pop_req && (q.cnt != '0);
        do_push = push && !full;
        if (flush) begin
            n.wp  = '0;
            n.rp  = '0;
            n.cnt = '0;
            n.ovf = 1'b0;
        end else begin
            if (do_push) begin
                n.mem[q.wp] = pdata;
                n.wp        = step(q.wp);
            end
            if (do_pop) n.rp = step(q.rp);
            n.cnt = q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
            if (push && full) n.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wp  <= '0;
            q.rp  <= '0;
            q.cnt <= '0;
            q.ovf <= 1'b0;
            for (int i = 0; i < DEPTH; i++) q.mem[i] <= '0;
        end else begin
            q <= n;
        end
    end

    assign rd_data = (q.cnt != '0) ? q.mem[q.rp] : '0;
    assign count   = q.cnt;
    assign ovf     = q.ovf;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q.cnt == CNT_W'(DEPTH) && !pop_req && !flush)
            |=> (q.cnt == CNT_W'(DEPTH) && q.ovf));
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q.cnt == '0 && !q.ovf));
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && q.cnt == '0 && !push && !flush) |=> (q.cnt == '0));
endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
    import i2s_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       flush,
    input  logic                       is_master,
    input  logic                       bits16,
    input  logic                       lr_pol,
    input  logic                       sck_i,
    input  logic                       ws_i,
    input  logic                       sd_i,
    output logic                       sck_o,
    output logic                       ws_o,
    input  logic                       rd_en,
    output logic [31:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic                       dma_req,
    output logic                       overflow
);
    logic  rise, ws_s, sd_s, push;
    word_t pdata;

    i2s_rx_clkgen #(.DIV(DIV)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .bits16(bits16),
        .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
        .sck_o(sck_o), .ws_o(ws_o), .rise(rise), .ws_s(ws_s), .sd_s(sd_s)
    );

    i2s_rx_deser u_deser (
        .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .bits16(bits16),
        .lr_pol(lr_pol), .rise(rise), .ws_s(ws_s), .sd_s(sd_s),
        .push(push), .pdata(pdata)
    );

    i2s_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pdata(pdata),
        .pop_req(rd_en), .rd_data(rd_data), .count(fifo_count), .ovf(overflow)
    );

    assign dma_req = (fifo_count != '0);
endmodule

// File: tb/i2s_rx_tb.sv
module i2s_rx_tb;
    localparam int DEPTH = 16;
    localparam int DIV   = 4;
    localparam int H     = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, flush = 1'b0, is_master = 1'b0, bits16 = 1'b1, lr_pol = 1'b0;
    logic sck_i = 1'b0, ws_i = 1'b1, sd_i = 1'b0, rd_en = 1'b0;
    logic sck_o, ws_o, dma_req, overflow;
    logic [31:0] rd_data;
    logic [CW-1:0] fifo_count;

    int n_chk = 0, n_bad = 0, cyc = 0, nb = 16;
    logic pol_b = 1'b0, carry = 1'b0, drain_on = 1'b0, m_on = 1'b0, done = 1'b0;
    logic [31:0] exp_q[$];
    string cur_tag = "R2";

    // master-mode transmitter state
    logic m_ws_last = 1'b0;
    logic [15:0] m_data = '0;
    logic m_carry = 1'b0;
    int m_j = 1, m_idx = 0, m_falls = 0, slot_len = 0;
    logic m_seen = 1'b0;

    i2s_rx #(.DEPTH(DEPTH), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .is_master(is_master),
        .bits16(bits16), .lr_pol(lr_pol), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
        .sck_o(sck_o), .ws_o(ws_o), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_count(fifo_count), .dma_req(dma_req), .overflow(overflow)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic period(input logic w, input logic d);
        @(negedge clk);
        sck_i = 1'b0; ws_i = w; sd_i = d;
        repeat (H) @(negedge clk);
        sck_i = 1'b1;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic send_word(input logic w, input logic [15:0] d);
        for (int j = 0; j < nb; j++) period(w, (j == 0) ? carry : d[nb - j]);
        carry = d[0];
    endtask

    task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
        send_word(pol_b, l);
        send_word(~pol_b, r);
    endtask

    function automatic logic [31:0] pack(input logic [15:0] l, input logic [15:0] r);
        return (nb == 16) ? {r, l} : {16'h0000, r[7:0], l[7:0]};
    endfunction

    task automatic expect_pair(input logic [15:0] l, input logic [15:0] r);
        exp_q.push_back(pack(l, r));
        send_pair(l, r);
    endtask

    task automatic finish_stream();
        period(pol_b, carry);
        period(~pol_b, 1'b0);
        repeat (10) @(negedge clk);
    endtask

    task automatic preamble();
        repeat (2) period(~pol_b, 1'b0);
    endtask

    task automatic read_check(input string req, input logic [31:0] exp);
        @(negedge clk);
        check_eq(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    // scoreboard monitor: drains the FIFO and compares against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (drain_on && dma_req) begin
                if (exp_q.size() == 0) begin
                    check_eq({cur_tag, " unexpected entry"}, rd_data, 32'hxxxxxxxx);
                end else begin
                    check_eq(cur_tag, rd_data, exp_q.pop_front());
                end
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
        end
    end

    // master-mode transmitter reacting to the generated clocks (R10)
    always @(negedge sck_o) begin
        if (m_on) begin
            if (ws_o != m_ws_last) begin
                if (m_seen) slot_len = m_falls;
                m_seen = 1'b1;
                m_falls = 1;
                m_ws_last = ws_o;
                m_data = ws_o ? (16'h3000 + 16'(m_idx)) : (16'hC000 + 16'(m_idx));
                if (ws_o) m_idx++;
                sd_i <= m_carry;
                m_carry = m_data[0];
                m_j = 1;
            end else begin
                m_falls++;
                sd_i <= (m_j < 16) ? m_data[16 - m_j] : 1'b0;
                m_j++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1, waited;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 count", 32'(fifo_count), 32'd0);
        check_eq("R1 dma", 32'(dma_req), 32'd0);
        check_eq("R1 overflow", 32'(overflow), 32'd0);
        check_eq("R1 rd_data", rd_data, 32'd0);

        preamble();
        // R5: disabled, nothing stored
        send_pair(16'h1111, 16'h2222);
        finish_stream();
        check_eq("R5 disabled", 32'(fifo_count), 32'd0);

        // R6: partial pair not counted; R2 packing
        @(negedge clk); en = 1'b1;
        send_word(pol_b, 16'hBEEF);
        repeat (6) @(negedge clk);
        check_eq("R6 after left", 32'(fifo_count), 32'd0);
        send_word(~pol_b, 16'h1234);
        repeat (6) @(negedge clk);
        check_eq("R6 lone left", 32'(fifo_count), 32'd0);
        finish_stream();
        check_eq("R6 pair counted", 32'(fifo_count), 32'd1);
        check_eq("R9 dma high", 32'(dma_req), 32'd1);
        read_check("R2 packing", 32'h1234BEEF);
        check_eq("R9 dma low", 32'(dma_req), 32'd0);

        // R9: empty read
        read_check("R9 empty read", 32'd0);
        check_eq("R9 count after empty read", 32'(fifo_count), 32'd0);

        // R2/R11: scoreboard traffic
        drain_on = 1'b1; cur_tag = "R2";
        expect_pair(16'hFFFF, 16'h0000);
        expect_pair(16'h8001, 16'h7FFE);
        expect_pair(16'hA5C3, 16'h3C5A);
        finish_stream();
        check_eq("R11 queue drained", 32'(exp_q.size()), 32'd0);

        // R4: high word select marks left
        en = 1'b0; pol_b = 1'b1; lr_pol = 1'b1;
        preamble();
        en = 1'b1; cur_tag = "R4";
        expect_pair(16'h0F0F, 16'hF0F0);
        expect_pair(16'h1357, 16'h2468);
        finish_stream();
        check_eq("R4 queue drained", 32'(exp_q.size()), 32'd0);

        // R3: 8-bit samples
        en = 1'b0; pol_b = 1'b0; lr_pol = 1'b0; nb = 8; bits16 = 1'b0;
        preamble();
        en = 1'b1; cur_tag = "R3";
        expect_pair(16'h00A5, 16'h003C);
        expect_pair(16'h0080, 16'h0001);
        expect_pair(16'h00FF, 16'h00FE);
        finish_stream();
        check_eq("R3 queue drained", 32'(exp_q.size()), 32'd0);
        drain_on = 1'b0;

        // R5: enable raised inside a left slot
        en = 1'b0; nb = 16; bits16 = 1'b1;
        preamble();
        fork
            send_pair(16'h7777, 16'h8888);
            begin
                repeat (3 * 2 * H + 4) @(negedge clk);
                en = 1'b1;
            end
        join
        send_pair(16'h4321, 16'h8765);
        finish_stream();
        check_eq("R5 mid-slot enable count", 32'(fifo_count), 32'd1);
        read_check("R5 first stored pair", 32'h87654321);

        // R7: overflow
        do_flush();
        for (int k = 0; k <= DEPTH; k++) send_pair(16'h0100 + 16'(k), 16'h0200 + 16'(k));
        finish_stream();
        check_eq("R7 full count", 32'(fifo_count), 32'(DEPTH));
        check_eq("R7 overflow set", 32'(overflow), 32'd1);
        read_check("R11 order first", 32'h02000100);
        read_check("R11 order second", 32'h02010101);
        check_eq("R11 one per read", 32'(fifo_count), 32'(DEPTH - 2));
        check_eq("R7 overflow sticky", 32'(overflow), 32'd1);

        // R8: flush
        do_flush();
        @(negedge clk);
        check_eq("R8 count", 32'(fifo_count), 32'd0);
        check_eq("R8 overflow", 32'(overflow), 32'd0);
        check_eq("R8 dma", 32'(dma_req), 32'd0);
        check_eq("R8 rd_data", rd_data, 32'd0);

        // R10: master mode
        en = 1'b0; m_on = 1'b1; is_master = 1'b1;
        @(posedge ws_o);
        repeat (2) @(negedge clk);
        m_idx = 0; en = 1'b1;
        @(posedge sck_o); t0 = cyc;
        @(posedge sck_o); t1 = cyc;
        check_eq("R10 bit clock period", 32'(t1 - t0), 32'(2 * DIV));
        waited = 0;
        while (fifo_count < 3 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        en = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R10 pairs captured", 32'(fifo_count), 32'd3);
        for (int k = 0; k < 3; k++)
            read_check("R10 master data", {16'h3000 + 16'(k), 16'hC000 + 16'(k)});
        check_eq("R10 slot length", 32'(slot_len), 32'd16);
        m_on = 1'b0; is_master = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule